// File: doc/BRIEF.md
# SCSI Initiator Command Decoder

This block takes the byte that software writes to the command register of a SCSI-style initiator controller and turns it into updates of three architectural registers: the status register, the interrupt-cause register and the sequence-step register. It also drives the interrupt request. The top bit of the command byte asks for DMA mode and the low seven bits name the operation. Chip reset, bus reset, FIFO flush, data transfer, the completion sequence, message acceptance, padding, attention, enabling selection and three forms of target selection are decoded. Any other code is dropped.

Real bus signalling is outside the block. The target number comes from a bus-ID input. A presence vector says which targets answer. A signed response length says whether a selected target wants to send data (positive), receive data (negative) or move no data (zero). Two neighbouring registers are not stored here. The FIFO-flags register and the configuration and identity registers are cleared or reloaded by one-cycle strobes. On a chip reset the neighbour loads configuration-1 with 7 and the identity register at offset 0xE with 0x04. A read of the interrupt-cause register acknowledges the interrupt through its own input.

All updates are registered. A command written on one clock edge is visible on the outputs after that edge, and its strobes are high for exactly that one cycle.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: After reset, status_q, intr_q and seq_q are zero, irq, dma_mode and cmd_collect are low, and both strobes are low. Bit 7 of status_q always equals irq.
- R2: For the codes 0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12, 0x18, 0x1A, 0x41, 0x42, 0x43 and 0x44 in bits 6:0, dma_mode takes bit 7 of the byte. Any other value of bits 6:0 leaves every output unchanged and pulses no strobe.
- R3: Flush (0x01) sets intr_q to 0x08, sets seq_q to 0 and pulses flags_clr. irq is unchanged.
- R4: Chip reset (0x02) clears status_q, intr_q, seq_q, irq, dma_mode and cmd_collect, and pulses chip_rst_stb.
- R5: Bus reset (0x03) sets intr_q to 0x80. It raises irq only when rst_rpt_dis is low.
- R6: Message accepted (0x12) sets intr_q to 0x20, sets seq_q to 0, pulses flags_clr and raises irq.
- R7: Pad (0x18) sets status bits 6:0 to 0x10, intr_q to 0x08 and seq_q to 0. irq is unchanged.
- R8: A select (0x41, 0x42 or 0x43) to a target whose bit in tgt_present (indexed by bus_id) is 0 sets status bits 6:0 to 0, intr_q to 0x20 and seq_q to 0, clears cmd_collect and raises irq.
- R9: A select without stop (0x41 or 0x42) to a present target sets intr_q to 0x18 and seq_q to 4, clears cmd_collect and raises irq. Status bits 6:0 become 0x11 when resp_len > 0, become 0x10 when resp_len < 0, and stay unchanged when resp_len = 0.
- R10: Select with stop (0x43) to a present target sets status bits 6:0 to 0x12, intr_q to 0x18 and seq_q to 4, sets cmd_collect and raises irq.
- R11: Transfer (0x10) with cmd_collect high clears cmd_collect and has the same outcome as R9 for the current resp_len, without a presence check. With cmd_collect low it clears status bit 4 when bit 7 of the byte is set, and otherwise leaves the registers unchanged.
- R12: Command-complete (0x11) sets intr_q to 0x08, sets status bits 2:0 to 7 (the other bits are kept) and raises irq.
- R13: Enable selection (0x44) clears intr_q. NOP (0x00) and set-attention (0x1A) change nothing except dma_mode.
- R14: intr_rd clears intr_q, clears status bit 4, sets seq_q to 4 and lowers irq. When cmd_we is high in the same cycle, the command is applied and the read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_byte | input | 8 | Command byte: bit 7 is DMA, bits 6:0 are the operation |
| intr_rd | input | 1 | Read strobe for the interrupt-cause register |
| bus_id | input | ID_W (3) | Target number from the bus-ID register |
| tgt_present | input | NUM_TGT (8) | One bit per target: the target answers selection |
| resp_len | input | LEN_W (16) | Signed response length of the selected target |
| rst_rpt_dis | input | 1 | Configuration-1 bit 6: no interrupt on bus reset |
| status_q | output | 8 | Status register; bit 7 mirrors irq |
| intr_q | output | 8 | Interrupt-cause register |
| seq_q | output | 3 | Sequence-step register |
| irq | output | 1 | Interrupt request |
| dma_mode | output | 1 | DMA bit of the last defined command |
| cmd_collect | output | 1 | Command-collection mode after select with stop |
| flags_clr | output | 1 | One-cycle strobe: neighbour clears the FIFO-flags register |
| chip_rst_stb | output | 1 | One-cycle strobe: neighbour reloads configuration and identity registers |

## Verification
Every piece of state in this block is either a port or becomes one on the next command. A wrong phase, cause or step therefore shows on status_q, intr_q or seq_q on the cycle right after the command that should have set it. The one internal flag that can hide is command collection. It is made visible as cmd_collect, and a wrong value also changes what the next transfer command produces, so an error there shows at the latest one command later. A wrong interrupt level shows at once on both irq and status bit 7. It persists until an interrupt read, so a missed raise or a spurious raise is never masked by later commands that leave irq alone.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_CPLT, OP_MSGOK,
    OP_PAD, OP_ATN, OP_SEL, OP_SELATN, OP_SELSTOP, OP_ENSEL, OP_BAD
  } op_e;

  localparam logic [7:0] CAUSE_FC   = 8'h08;
  localparam logic [7:0] CAUSE_BS   = 8'h10;
  localparam logic [7:0] CAUSE_DISC = 8'h20;
  localparam logic [7:0] CAUSE_BRST = 8'h80;

  localparam logic [6:0] ST_TC      = 7'h10;
  localparam logic [6:0] ST_CMDPH   = 7'h02;
  localparam logic [6:0] ST_MSGIN   = 7'h07;
  localparam logic [2:0] STEP_DONE  = 3'd4;

  // Operation field to operation kind; anything unlisted is OP_BAD.
  function automatic op_e decode_op(input logic [6:0] code);
    case (code)
      7'h00: return OP_NOP;
      7'h01: return OP_FLUSH;
      7'h02: return OP_CHIPRST;
      7'h03: return OP_BUSRST;
      7'h10: return OP_XFER;
      7'h11: return OP_CPLT;
      7'h12: return OP_MSGOK;
      7'h18: return OP_PAD;
      7'h1A: return OP_ATN;
      7'h41: return OP_SEL;
      7'h42: return OP_SELATN;
      7'h43: return OP_SELSTOP;
      7'h44: return OP_ENSEL;
      default: return OP_BAD;
    endcase
  endfunction

  // Status after a data-phase entry: terminal count plus data-in or
  // data-out, or the old value when no data is expected.
  function automatic logic [6:0] data_phase(input logic [6:0] cur,
                                            input logic len_pos,
                                            input logic len_zero);
    if (len_zero) return cur;
    return ST_TC | {6'd0, len_pos};
  endfunction

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_cmd_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output op_e        op,
  output logic       dma_bit,
  output logic       defined
);
  assign op      = decode_op(cmd_byte[6:0]);
  assign dma_bit = cmd_byte[7];
  assign defined = (op != OP_BAD);
endmodule

// File: rtl/scsi_tgt_check.sv
module scsi_tgt_check #(
  parameter int NUM_TGT = 8,
  parameter int LEN_W   = 16,
  localparam int ID_W   = $clog2(NUM_TGT)
) (
  input  logic [ID_W-1:0]         bus_id,
  input  logic [NUM_TGT-1:0]      tgt_present,
  input  logic signed [LEN_W-1:0] resp_len,
  output logic                    present,
  output logic                    len_pos,
  output logic                    len_zero
);
  assign present  = tgt_present[bus_id];
  assign len_zero = (resp_len == '0);
  assign len_pos  = !resp_len[LEN_W-1] && !len_zero;
endmodule

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
  import scsi_cmd_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int LEN_W   = 16,
  localparam int ID_W   = $clog2(NUM_TGT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_we,
  input  logic [7:0]              cmd_byte,
  input  logic                    intr_rd,
  input  logic [ID_W-1:0]         bus_id,
  input  logic [NUM_TGT-1:0]      tgt_present,
  input  logic signed [LEN_W-1:0] resp_len,
  input  logic                    rst_rpt_dis,
  output logic [7:0]              status_q,
  output logic [7:0]              intr_q,
  output logic [2:0]              seq_q,
  output logic                    irq,
  output logic                    dma_mode,
  output logic                    cmd_collect,
  output logic                    flags_clr,
  output logic                    chip_rst_stb
);

  op_e  op;
  logic dma_bit, defined, present, len_pos, len_zero;

  scsi_cmd_decode u_dec (
    .cmd_byte (cmd_byte),
    .op       (op),
    .dma_bit  (dma_bit),
    .defined  (defined)
  );

  scsi_tgt_check #(.NUM_TGT(NUM_TGT), .LEN_W(LEN_W)) u_tgt (
    .bus_id      (bus_id),
    .tgt_present (tgt_present),
    .resp_len    (resp_len),
    .present     (present),
    .len_pos     (len_pos),
    .len_zero    (len_zero)
  );

  // Named events for the assertions.
  logic ev_cmd, ev_sel, ev_miss, ev_ack;
  assign ev_cmd  = cmd_we && defined;
  assign ev_sel  = ev_cmd && (op == OP_SEL || op == OP_SELATN || op == OP_SELSTOP);
  assign ev_miss = ev_sel && !present;
  assign ev_ack  = intr_rd && !cmd_we;

  logic [6:0] st_q, st_d;
  logic [7:0] in_d;
  logic [2:0] sq_d;
  logic       irq_d, dma_d, col_d, fc_d, cr_d;

  always_comb begin
    st_d  = st_q;
    in_d  = intr_q;
    sq_d  = seq_q;
    irq_d = irq;
    dma_d = dma_mode;
    col_d = cmd_collect;
    fc_d  = 1'b0;
    cr_d  = 1'b0;
    if (ev_cmd) begin
      dma_d = dma_bit;
      if (ev_miss) begin
        st_d  = '0;
        in_d  = CAUSE_DISC;
        sq_d  = '0;
        irq_d = 1'b1;
        col_d = 1'b0;
      end else begin
        unique case (op)
          OP_FLUSH: begin
            in_d = CAUSE_FC;
            sq_d = '0;
            fc_d = 1'b1;
          end
          OP_CHIPRST: begin
            st_d  = '0;
            in_d  = '0;
            sq_d  = '0;
            irq_d = 1'b0;
            dma_d = 1'b0;
            col_d = 1'b0;
            cr_d  = 1'b1;
          end
          OP_BUSRST: begin
            in_d = CAUSE_BRST;
            if (!rst_rpt_dis) irq_d = 1'b1;
          end
          OP_XFER: begin
            if (cmd_collect) begin
              col_d = 1'b0;
              st_d  = data_phase(st_q, len_pos, len_zero);
              in_d  = CAUSE_BS | CAUSE_FC;
              sq_d  = STEP_DONE;
              irq_d = 1'b1;
            end else if (dma_bit) begin
              st_d[4] = 1'b0;
            end
          end
          OP_CPLT: begin
            in_d  = CAUSE_FC;
            st_d  = st_q | ST_MSGIN;
            irq_d = 1'b1;
          end
          OP_MSGOK: begin
            in_d  = CAUSE_DISC;
            sq_d  = '0;
            fc_d  = 1'b1;
            irq_d = 1'b1;
          end
          OP_PAD: begin
            st_d = ST_TC;
            in_d = CAUSE_FC;
            sq_d = '0;
          end
          OP_SEL, OP_SELATN: begin
            st_d  = data_phase(st_q, len_pos, len_zero);
            in_d  = CAUSE_BS | CAUSE_FC;
            sq_d  = STEP_DONE;
            irq_d = 1'b1;
            col_d = 1'b0;
          end
          OP_SELSTOP: begin
            st_d  = ST_TC | ST_CMDPH;
            in_d  = CAUSE_BS | CAUSE_FC;
            sq_d  = STEP_DONE;
            irq_d = 1'b1;
            col_d = 1'b1;
          end
          OP_ENSEL: in_d = '0;
          default: ;
        endcase
      end
    end else if (ev_ack) begin
      in_d    = '0;
      st_d[4] = 1'b0;
      sq_d    = STEP_DONE;
      irq_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= '0;
      intr_q       <= '0;
      seq_q        <= '0;
      irq          <= 1'b0;
      dma_mode     <= 1'b0;
      cmd_collect  <= 1'b0;
      flags_clr    <= 1'b0;
      chip_rst_stb <= 1'b0;
    end else begin
      st_q         <= st_d;
      intr_q       <= in_d;
      seq_q        <= sq_d;
      irq          <= irq_d;
      dma_mode     <= dma_d;
      cmd_collect  <= col_d;
      flags_clr    <= fc_d;
      chip_rst_stb <= cr_d;
    end
  end

  assign status_q = {irq, st_q};

  // Assertions guarding the update logic.
  assert_undef_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !defined) |=> ($stable(status_q) && $stable(intr_q) && $stable(seq_q)
                              && $stable(dma_mode) && !flags_clr && !chip_rst_stb));

  assert_chip_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && op == OP_CHIPRST) |=> (status_q == 8'h00 && intr_q == 8'h00
                                      && !cmd_collect && chip_rst_stb));

  assert_busrst_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && op == OP_BUSRST && rst_rpt_dis && !irq) |=> (!irq && intr_q == CAUSE_BRST));

  assert_miss_disc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (irq && intr_q == CAUSE_DISC && seq_q == 3'd0 && !cmd_collect));

  assert_stop_collect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel && present && op == OP_SELSTOP) |=> (cmd_collect && status_q[6:0] == 7'h12));

  assert_ack_lower_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> (!irq && intr_q == 8'h00 && seq_q == STEP_DONE && !status_q[4]));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags_clr, chip_rst_stb}));

endmodule

// File: tb/scsi_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module scsi_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic        intr_rd = 1'b0;
  logic [2:0]  bus_id = 3'd0;
  logic [7:0]  tgt_present = 8'h00;
  logic signed [15:0] resp_len = 16'sd0;
  logic        rst_rpt_dis = 1'b0;
  logic [7:0]  status_q, intr_q;
  logic [2:0]  seq_q;
  logic        irq, dma_mode, cmd_collect, flags_clr, chip_rst_stb;

  always #2 clk = ~clk;

  scsi_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .intr_rd(intr_rd), .bus_id(bus_id), .tgt_present(tgt_present),
    .resp_len(resp_len), .rst_rpt_dis(rst_rpt_dis),
    .status_q(status_q), .intr_q(intr_q), .seq_q(seq_q), .irq(irq),
    .dma_mode(dma_mode), .cmd_collect(cmd_collect),
    .flags_clr(flags_clr), .chip_rst_stb(chip_rst_stb)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side expected state.
  logic [6:0] m_st = '0;
  logic [7:0] m_in = '0;
  logic [2:0] m_sq = '0;
  logic       m_irq = 0, m_dma = 0, m_col = 0, m_fc = 0, m_cr = 0;

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "status", status_q, {m_irq, m_st});
    chk(tag, "intr",   intr_q, m_in);
    chk(tag, "seq",    {5'd0, seq_q}, {5'd0, m_sq});
    chk(tag, "irq",    {7'd0, irq}, {7'd0, m_irq});
    chk(tag, "dma",    {7'd0, dma_mode}, {7'd0, m_dma});
    chk(tag, "collect",{7'd0, cmd_collect}, {7'd0, m_col});
    chk(tag, "flags_clr", {7'd0, flags_clr}, {7'd0, m_fc});
    chk(tag, "chip_rst",  {7'd0, chip_rst_stb}, {7'd0, m_cr});
  endtask

  function automatic string tag_of(input logic [7:0] c, input logic pres);
    case (c[6:0])
      7'h01: return "R3";
      7'h02: return "R4";
      7'h03: return "R5";
      7'h10: return "R11";
      7'h11: return "R12";
      7'h12: return "R6";
      7'h18: return "R7";
      7'h41, 7'h42: return pres ? "R9" : "R8";
      7'h43: return pres ? "R10" : "R8";
      7'h00, 7'h1A, 7'h44: return "R13";
      default: return "R2";
    endcase
  endfunction

  // Expected status after a data-phase entry, from the sign of resp_len.
  function automatic logic [6:0] phase_exp(input logic [6:0] cur);
    if (resp_len > 0) return 7'h11;
    if (resp_len < 0) return 7'h10;
    return cur;
  endfunction

  task automatic model_cmd(input logic [7:0] c);
    logic pres;
    pres = tgt_present[bus_id];
    m_fc = 0; m_cr = 0;
    if (!(c[6:0] inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12,
                          7'h18, 7'h1A, 7'h41, 7'h42, 7'h43, 7'h44})) return;
    m_dma = c[7];
    if (c[6:0] inside {7'h41, 7'h42, 7'h43} && !pres) begin
      m_st = 0; m_in = 8'h20; m_sq = 0; m_irq = 1; m_col = 0;
      return;
    end
    case (c[6:0])
      7'h01: begin m_in = 8'h08; m_sq = 0; m_fc = 1; end
      7'h02: begin m_st = 0; m_in = 0; m_sq = 0; m_irq = 0; m_dma = 0; m_col = 0; m_cr = 1; end
      7'h03: begin m_in = 8'h80; if (!rst_rpt_dis) m_irq = 1; end
      7'h10: begin
        if (m_col) begin
          m_col = 0; m_st = phase_exp(m_st); m_in = 8'h18; m_sq = 4; m_irq = 1;
        end else if (c[7]) m_st = m_st & 7'h6F;
      end
      7'h11: begin m_in = 8'h08; m_st = m_st | 7'h07; m_irq = 1; end
      7'h12: begin m_in = 8'h20; m_sq = 0; m_fc = 1; m_irq = 1; end
      7'h18: begin m_st = 7'h10; m_in = 8'h08; m_sq = 0; end
      7'h41, 7'h42: begin m_st = phase_exp(m_st); m_in = 8'h18; m_sq = 4; m_irq = 1; m_col = 0; end
      7'h43: begin m_st = 7'h12; m_in = 8'h18; m_sq = 4; m_irq = 1; m_col = 1; end
      7'h44: m_in = 0;
      default: ;
    endcase
  endtask

  task automatic do_cmd(input logic [7:0] c, input string tag);
    @(negedge clk);
    cmd_byte = c; cmd_we = 1;
    @(negedge clk);
    cmd_we = 0;
    model_cmd(c);
    chk_all(tag);
  endtask

  task automatic do_rd();
    @(negedge clk);
    intr_rd = 1;
    @(negedge clk);
    intr_rd = 0;
    m_fc = 0; m_cr = 0;
    m_in = 0; m_st = m_st & 7'h6F; m_sq = 4; m_irq = 0;
    chk_all("R14");
  endtask

  logic [7:0] pats [4] = '{8'hFF, 8'h00, 8'h5A, 8'hC3};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1");

    // Directed: select with stop, then transfer completes the command (R10, R11).
    tgt_present = 8'h04; bus_id = 3'd2; resp_len = -16'sd6;
    do_cmd(8'h43, "R10");
    do_cmd(8'h10, "R11");
    // Bus reset with reporting suppressed after acknowledge (R5).
    do_rd();
    rst_rpt_dis = 1;
    do_cmd(8'h03, "R5");
    rst_rpt_dis = 0;
    // Command and read in the same cycle: command wins (R14).
    @(negedge clk);
    cmd_byte = 8'h12; cmd_we = 1; intr_rd = 1;
    @(negedge clk);
    cmd_we = 0; intr_rd = 0;
    model_cmd(8'h12);
    chk_all("R14");
    do_cmd(8'h02, "R4");

    // Sweep of every command byte under four input settings.
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 256; c++) begin
        tgt_present = pats[p];
        bus_id      = 3'((c + p) % 8);
        rst_rpt_dis = p[0];
        case (c % 3)
          0: resp_len = 16'sd9;
          1: resp_len = 16'sd0;
          default: resp_len = -16'sd4;
        endcase
        if (m_irq && (c % 4 == 0)) do_rd();
        do_cmd(8'(c), tag_of(8'(c), tgt_present[bus_id]));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule